// File: doc/BRIEF.md
# T1 AIS insertion controller

This block sits in front of four T1 line ports. For each port, and in each direction, it decides whether the line carries the normal bit stream or an alarm indication signal (AIS). AIS is an unframed run of all ones that replaces every bit on the line, framing bits included. Defect detection, pointer processing, framing and the FIFOs are outside the block. Their results reach it as flags.

On the receive side, each port watches two redundant drop sides, A and B. A per-port side-select bit chooses which side's defect flags count. Some defects always count once receive AIS is enabled. Others are gated by common qualifier bits. A receive FIFO error raises AIS at once. AIS then stays up through one complete multiframe, which runs from the next multiframe boundary pulse to the one after it. A per-port software force bit raises receive AIS whatever else is true. On the transmit side, a port sends AIS when transmit AIS is enabled and its line input has lost signal or clock.

The block runs on one system clock. The line bit rate is given by a bit strobe. Line outputs change only in strobe cycles, so a switch between data and all ones always falls on a whole bit. Each port also has a registered AIS-active status for each direction.

Top module: `ais_insert_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all data outputs and all AIS status outputs are 0.
- R2: `side_sel_i[p]`=0 makes port p use `def_a_i` and 1 makes it use `def_b_i`. The flags of the side not selected have no effect on `rx_ais_o[p]`.
- R3: Within a port's 7-bit defect field, bit 0 (loss of pointer), bit 1 (path AIS seen), bit 2 (drop clock loss) and bit 6 (label mismatch) each raise receive AIS whenever `rx_ais_en_i`=1.
- R4: Bit 3 (upstream AIS) counts only while `uais_qual_i`=1.
- R5: Bit 4 (H4 error) counts only while `h4_ignore_i`=0.
- R6: Bit 5 (unequipped label) counts only while `uneq_qual_i`=1.
- R7: While `rx_ais_en_i`=0, defect flags and FIFO errors raise no receive AIS. A hold that is already running still completes.
- R8: A FIFO error while receive AIS is enabled raises AIS in the next cycle. AIS stays up until the boundary pulse after the first boundary pulse that follows the error. An error in the same cycle as a boundary pulse counts as before it. An error during the hold makes the hold run to the boundary after the next one.
- R9: `force_rx_i[p]`=1 raises `rx_ais_o[p]` regardless of enables and defects.
- R10: `tx_ais_o[p]` is 1 exactly when, one cycle earlier, `tx_ais_en_i`=1 and either `los_i[p]` or `loc_i[p]` was 1.
- R11: A data output changes only in a cycle after one in which `bit_en_i`=1. It then takes 1 if that direction's status output was 1 in the strobe cycle, and otherwise the data input.
- R12: Status outputs are registered and follow their condition with a latency of exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en_i | input | 1 | Line bit strobe |
| mf_pulse_i | input | NP | Per-port multiframe boundary pulse |
| rx_ais_en_i | input | 1 | Common receive AIS enable |
| tx_ais_en_i | input | 1 | Common transmit AIS enable |
| uais_qual_i | input | 1 | Upstream AIS counts when 1 |
| h4_ignore_i | input | 1 | H4 error ignored when 1 |
| uneq_qual_i | input | 1 | Unequipped label counts when 1 |
| side_sel_i | input | NP | Per-port drop side, 0=A, 1=B |
| force_rx_i | input | NP | Per-port software receive AIS force |
| fifo_err_i | input | NP | Per-port receive FIFO error |
| def_a_i | input | NP*7 | Side A defect fields, port p at bits [7p+6:7p] |
| def_b_i | input | NP*7 | Side B defect fields, same layout |
| los_i | input | NP | Transmit line loss of signal |
| loc_i | input | NP | Transmit line loss of clock |
| rx_data_i | input | NP | Receive line data in |
| tx_data_i | input | NP | Transmit line data in |
| rx_data_o | output | NP | Receive line data out |
| tx_data_o | output | NP | Transmit line data out |
| rx_ais_o | output | NP | Receive AIS active status |
| tx_ais_o | output | NP | Transmit AIS active status |

## Verification
Two receive events can land in the same cycle: a FIFO error and a multiframe boundary pulse. They should act as an error just before the boundary, so the hold starts at once or restarts. The bench places errors exactly on the pulse, both from idle and in the middle of a hold. Random stimulus also produces the same overlap while defects or the force bit are active at the moment the hold ends. A bench model built from the requirements compares every status and data output in every cycle.

// File: rtl/ais_ctrl_pkg.sv
package ais_ctrl_pkg;
  localparam int DEF_W    = 7;
  localparam int DEF_LOP  = 0;
  localparam int DEF_PAIS = 1;
  localparam int DEF_DLOC = 2;
  localparam int DEF_UAIS = 3;
  localparam int DEF_H4   = 4;
  localparam int DEF_UNEQ = 5;
  localparam int DEF_SLM  = 6;

  typedef struct packed {
    logic uais_qual;
    logic h4_ignore;
    logic uneq_qual;
  } qual_cfg_t;
endpackage

// File: rtl/ais_defect_sel.sv
module ais_defect_sel
  import ais_ctrl_pkg::*;
(
  input  logic [DEF_W-1:0] def_a_i,
  input  logic [DEF_W-1:0] def_b_i,
  input  logic             side_sel_i,
  input  qual_cfg_t        cfg_i,
  output logic             hit_o
);
  logic [DEF_W-1:0] chosen;
  logic             hard_hit;
  logic             soft_hit;

  always_comb begin
    chosen   = side_sel_i ? def_b_i : def_a_i;
    hard_hit = chosen[DEF_LOP] | chosen[DEF_PAIS] | chosen[DEF_DLOC] | chosen[DEF_SLM];
    soft_hit = (chosen[DEF_UAIS] & cfg_i.uais_qual)
             | (chosen[DEF_H4]   & ~cfg_i.h4_ignore)
             | (chosen[DEF_UNEQ] & cfg_i.uneq_qual);
    hit_o    = hard_hit | soft_hit;
  end
endmodule

// File: rtl/ais_mf_hold.sv
module ais_mf_hold (
  input  logic clk,
  input  logic rst,
  input  logic err_i,
  input  logic mf_i,
  output logic active_o
);
  logic pend_q;
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (mf_i) begin
      pend_q <= 1'b0;
      hold_q <= pend_q | err_i;
    end else begin
      pend_q <= pend_q | err_i;
    end
  end

  assign active_o = pend_q | hold_q;
endmodule

// File: rtl/ais_line_out.sv
module ais_line_out #(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en_i,
  input  logic [NP-1:0] data_i,
  input  logic [NP-1:0] ais_i,
  output logic [NP-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst)           data_o <= '0;
    else if (bit_en_i) data_o <= data_i | ais_i;
  end
endmodule

// File: rtl/ais_insert_ctrl.sv
module ais_insert_ctrl
  import ais_ctrl_pkg::*;
#(
  parameter int NP = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en_i,
  input  logic [NP-1:0]      mf_pulse_i,
  input  logic               rx_ais_en_i,
  input  logic               tx_ais_en_i,
  input  logic               uais_qual_i,
  input  logic               h4_ignore_i,
  input  logic               uneq_qual_i,
  input  logic [NP-1:0]      side_sel_i,
  input  logic [NP-1:0]      force_rx_i,
  input  logic [NP-1:0]      fifo_err_i,
  input  logic [NP*DEF_W-1:0] def_a_i,
  input  logic [NP*DEF_W-1:0] def_b_i,
  input  logic [NP-1:0]      los_i,
  input  logic [NP-1:0]      loc_i,
  input  logic [NP-1:0]      rx_data_i,
  input  logic [NP-1:0]      tx_data_i,
  output logic [NP-1:0]      rx_data_o,
  output logic [NP-1:0]      tx_data_o,
  output logic [NP-1:0]      rx_ais_o,
  output logic [NP-1:0]      tx_ais_o
);
  qual_cfg_t     cfg;
  logic [NP-1:0] defect_hit;
  logic [NP-1:0] hold_act;
  logic [NP-1:0] rx_cond;
  logic [NP-1:0] tx_cond;

  assign cfg = '{uais_qual: uais_qual_i, h4_ignore: h4_ignore_i, uneq_qual: uneq_qual_i};

  for (genvar p = 0; p < NP; p++) begin : g_port
    ais_defect_sel u_sel (
      .def_a_i    (def_a_i[p*DEF_W +: DEF_W]),
      .def_b_i    (def_b_i[p*DEF_W +: DEF_W]),
      .side_sel_i (side_sel_i[p]),
      .cfg_i      (cfg),
      .hit_o      (defect_hit[p])
    );

    ais_mf_hold u_hold (
      .clk      (clk),
      .rst      (rst),
      .err_i    (fifo_err_i[p] & rx_ais_en_i),
      .mf_i     (mf_pulse_i[p]),
      .active_o (hold_act[p])
    );

    assign rx_cond[p] = force_rx_i[p] | hold_act[p]
                      | (rx_ais_en_i & (defect_hit[p] | fifo_err_i[p]));
    assign tx_cond[p] = tx_ais_en_i & (los_i[p] | loc_i[p]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ais_o <= '0;
      tx_ais_o <= '0;
    end else begin
      rx_ais_o <= rx_cond;
      tx_ais_o <= tx_cond;
    end
  end

  ais_line_out #(.NP(NP)) u_rx_out (
    .clk      (clk),
    .rst      (rst),
    .bit_en_i (bit_en_i),
    .data_i   (rx_data_i),
    .ais_i    (rx_ais_o),
    .data_o   (rx_data_o)
  );

  ais_line_out #(.NP(NP)) u_tx_out (
    .clk      (clk),
    .rst      (rst),
    .bit_en_i (bit_en_i),
    .data_i   (tx_data_i),
    .ais_i    (tx_ais_o),
    .data_o   (tx_data_o)
  );
endmodule

// File: rtl/ais_insert_ctrl_chk.sv
module ais_insert_ctrl_chk #(
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_en_i,
  input logic          tx_ais_en_i,
  input logic [NP-1:0] force_rx_i,
  input logic [NP-1:0] los_i,
  input logic [NP-1:0] loc_i,
  input logic [NP-1:0] rx_data_o,
  input logic [NP-1:0] tx_data_o,
  input logic [NP-1:0] rx_ais_o,
  input logic [NP-1:0] tx_ais_o
);
  for (genvar p = 0; p < NP; p++) begin : g_chk
    AST_FORCE_RAISES: assert property (@(posedge clk) disable iff (rst)
      force_rx_i[p] |=> rx_ais_o[p]); // R9
    AST_TX_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
      tx_ais_en_i && (los_i[p] || loc_i[p]) |=> tx_ais_o[p]); // R10
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
      !tx_ais_en_i |=> !tx_ais_o[p]); // R10
    AST_RX_ONES: assert property (@(posedge clk) disable iff (rst)
      bit_en_i && rx_ais_o[p] |=> rx_data_o[p]); // R11
    AST_TX_ONES: assert property (@(posedge clk) disable iff (rst)
      bit_en_i && tx_ais_o[p] |=> tx_data_o[p]); // R11
  end
  AST_RX_HOLD_BIT: assert property (@(posedge clk) disable iff (rst)
    !bit_en_i |=> $stable(rx_data_o)); // R11
  AST_TX_HOLD_BIT: assert property (@(posedge clk) disable iff (rst)
    !bit_en_i |=> $stable(tx_data_o)); // R11
endmodule

bind ais_insert_ctrl ais_insert_ctrl_chk #(.NP(NP)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bit_en_i    (bit_en_i),
  .tx_ais_en_i (tx_ais_en_i),
  .force_rx_i  (force_rx_i),
  .los_i       (los_i),
  .loc_i       (loc_i),
  .rx_data_o   (rx_data_o),
  .tx_data_o   (tx_data_o),
  .rx_ais_o    (rx_ais_o),
  .tx_ais_o    (tx_ais_o)
);

// File: tb/ais_insert_ctrl_tb.sv
module ais_insert_ctrl_tb;
  localparam int NP = 4;
  localparam int DW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en;
  logic [NP-1:0] mf, side, frc, ferr, los, loc, rxd, txd;
  logic rx_en, tx_en, uq, h4i, unq;
  logic [NP*DW-1:0] da, db;
  logic [NP-1:0] rx_do, tx_do, rx_act, tx_act;

  int total = 0;
  int bad = 0;

  // bench model state
  logic [NP-1:0] m_pend, m_hold, m_rxa, m_txa, m_rxd, m_txd;

  always #2.5 clk = ~clk;

  ais_insert_ctrl #(.NP(NP)) u_dut (
    .clk(clk), .rst(rst), .bit_en_i(bit_en), .mf_pulse_i(mf),
    .rx_ais_en_i(rx_en), .tx_ais_en_i(tx_en), .uais_qual_i(uq),
    .h4_ignore_i(h4i), .uneq_qual_i(unq), .side_sel_i(side),
    .force_rx_i(frc), .fifo_err_i(ferr), .def_a_i(da), .def_b_i(db),
    .los_i(los), .loc_i(loc), .rx_data_i(rxd), .tx_data_i(txd),
    .rx_data_o(rx_do), .tx_data_o(tx_do), .rx_ais_o(rx_act), .tx_ais_o(tx_act)
  );

  function automatic logic counts(input logic [DW-1:0] d);
    return d[0] | d[1] | d[2] | d[6] | (d[3] & uq) | (d[4] & ~h4i) | (d[5] & unq);
  endfunction

  task automatic chk(input string tag, input string what, input int p,
                     input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s port %0d actual=%b expected=%b", tag, what, p, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    for (int p = 0; p < NP; p++) begin
      chk(tag, "rx_ais", p, rx_act[p], m_rxa[p]);
      chk(tag, "tx_ais", p, tx_act[p], m_txa[p]);
      chk(tag, "rx_data", p, rx_do[p], m_rxd[p]);
      chk(tag, "tx_data", p, tx_do[p], m_txd[p]);
    end
  endtask

  // advance one clock, updating the model from the inputs now driven, then compare
  task automatic step(input string tag);
    logic [NP-1:0] n_pend, n_hold, n_rxa, n_txa, n_rxd, n_txd;
    for (int p = 0; p < NP; p++) begin
      logic e, hit;
      e   = ferr[p] & rx_en;
      hit = counts(side[p] ? db[p*DW +: DW] : da[p*DW +: DW]);
      n_pend[p] = mf[p] ? 1'b0 : (m_pend[p] | e);
      n_hold[p] = mf[p] ? (m_pend[p] | e) : m_hold[p];
      n_rxa[p]  = frc[p] | m_pend[p] | m_hold[p] | (rx_en & (hit | ferr[p]));
      n_txa[p]  = tx_en & (los[p] | loc[p]);
      n_rxd[p]  = bit_en ? (m_rxa[p] | rxd[p]) : m_rxd[p];
      n_txd[p]  = bit_en ? (m_txa[p] | txd[p]) : m_txd[p];
    end
    @(posedge clk);
    if (rst) begin
      m_pend = '0; m_hold = '0; m_rxa = '0; m_txa = '0; m_rxd = '0; m_txd = '0;
    end else begin
      m_pend = n_pend; m_hold = n_hold; m_rxa = n_rxa;
      m_txa = n_txa; m_rxd = n_rxd; m_txd = n_txd;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet();
    bit_en = 1'b0; mf = '0; side = '0; frc = '0; ferr = '0; los = '0; loc = '0;
    rxd = '0; txd = '0; da = '0; db = '0;
    rx_en = 1'b1; tx_en = 1'b1; uq = 1'b0; h4i = 1'b1; unq = 1'b0;
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    quiet();
    m_pend = '0; m_hold = '0; m_rxa = '0; m_txa = '0; m_rxd = '0; m_txd = '0;
    frc = '1; los = '1; rxd = '1; txd = '1; bit_en = 1'b1;
    @(negedge clk);
    step("R1"); step("R1");
    quiet();
    rst = 1'b0;
    step("R1");

    // R3: unconditional defects on side A and side B
    for (int b = 0; b < DW; b++) begin
      if (b == 0 || b == 1 || b == 2 || b == 6) begin
        quiet();
        da[0*DW + b] = 1'b1;
        side[1] = 1'b1; db[1*DW + b] = 1'b1;
        step("R3"); step("R3");
      end
    end
    // R2: other side is ignored
    quiet();
    db[2*DW +: DW] = 7'h7F; da[3*DW +: DW] = 7'h7F; side[3] = 1'b1;
    uq = 1'b1; h4i = 1'b0; unq = 1'b1;
    step("R2"); step("R2");
    // R4: upstream AIS qualifier
    quiet(); da[0*DW + 3] = 1'b1; step("R4"); step("R4");
    uq = 1'b1; step("R4"); step("R4");
    // R5: H4 qualifier, counts when ignore is 0
    quiet(); da[1*DW + 4] = 1'b1; step("R5"); step("R5");
    h4i = 1'b0; step("R5"); step("R5");
    // R6: unequipped qualifier
    quiet(); da[2*DW + 5] = 1'b1; step("R6"); step("R6");
    unq = 1'b1; step("R6"); step("R6");
    // R7: receive disabled
    quiet(); rx_en = 1'b0; da = '1; db = '1; ferr = '1; uq = 1'b1; h4i = 1'b0; unq = 1'b1;
    step("R7"); step("R7"); step("R7");
    // R9: force with receive disabled
    quiet(); rx_en = 1'b0; frc = 4'b0101; step("R9"); step("R9");
    // R8: FIFO error hold across a multiframe
    quiet(); step("R8");
    ferr[0] = 1'b1; step("R8"); ferr[0] = 1'b0;
    for (int i = 0; i < 4; i++) step("R8");
    mf[0] = 1'b1; step("R8"); mf[0] = 1'b0;
    for (int i = 0; i < 3; i++) step("R8");
    ferr[0] = 1'b1; step("R8"); ferr[0] = 1'b0;
    mf[0] = 1'b1; step("R8"); mf[0] = 1'b0;
    step("R8");
    mf[0] = 1'b1; step("R8"); mf[0] = 1'b0;
    step("R8");
    // R8: error in the same cycle as the boundary
    ferr[1] = 1'b1; mf[1] = 1'b1; step("R8"); ferr[1] = 1'b0; mf[1] = 1'b0;
    step("R8"); step("R8");
    mf[1] = 1'b1; step("R8"); mf[1] = 1'b0; step("R8");
    // R10: transmit AIS
    quiet(); los[0] = 1'b1; loc[2] = 1'b1; step("R10"); step("R10");
    tx_en = 1'b0; step("R10"); step("R10");
    // R11: data path, strobed
    quiet();
    for (int i = 0; i < 16; i++) begin
      rxd = NP'(i); txd = NP'(~i); bit_en = i[0]; frc[3] = i[2]; los[1] = i[3];
      step("R11");
    end

    // R12: random mix
    for (int i = 0; i < 3000; i++) begin
      bit_en = $urandom_range(0, 1) == 1;
      rx_en  = $urandom_range(0, 7) != 0;
      tx_en  = $urandom_range(0, 7) != 0;
      uq = $urandom_range(0, 1) == 1; h4i = $urandom_range(0, 1) == 1;
      unq = $urandom_range(0, 1) == 1;
      for (int p = 0; p < NP; p++) begin
        mf[p]   = $urandom_range(0, 15) == 0;
        ferr[p] = $urandom_range(0, 31) == 0;
        frc[p]  = $urandom_range(0, 15) == 0;
        side[p] = $urandom_range(0, 1) == 1;
        los[p]  = $urandom_range(0, 7) == 0;
        loc[p]  = $urandom_range(0, 7) == 0;
        rxd[p]  = $urandom_range(0, 1) == 1;
        txd[p]  = $urandom_range(0, 1) == 1;
        da[p*DW +: DW] = ($urandom_range(0, 3) == 0) ? DW'(1 << $urandom_range(0, DW-1)) : '0;
        db[p*DW +: DW] = ($urandom_range(0, 3) == 0) ? DW'(1 << $urandom_range(0, DW-1)) : '0;
      end
      step("R12");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule